// File: doc/BRIEF.md
# SDRAM Byte Mask Latency Pipeline

This block applies the two byte-mask inputs of a 16-bit synchronous DRAM data path. The same mask inputs act in two ways. In a write cycle they act at once: a byte whose mask bit is high is not written, and the write enables and gated write data show this in the same cycle. In a read cycle they act as output enables two clock edges later: a byte whose mask bit is sampled high on a read edge is held at high impedance when its data would be driven. The block drives this as a low output enable, with the read data forced to zero.

The read side has one delay line for each byte lane and one for the read indication. These registers shift on every clock, whatever the current mode, so a read-to-write turnaround needs no extra handling. The output enables come from the delayed values and the write enables from the current ones, and the two sides never interact. Tristate pads and CAS-latency alignment of data belong to the blocks around this one.

Top module: `sdr_byte_mask_gate`

## Requirements
- R1: There are two byte lanes. Lane 0 is data bits 7:0 and is controlled by mask bit 0. Lane 1 is bits 15:8 and is controlled by mask bit 1.
- R2: In the same cycle, wr_en_o[i] is 1 if and only if wr_i is 1 and mask_i[i] is 0. A high mask bit blocks the write of its byte.
- R3: oe_o[i] is 1 exactly two rising edges after an edge that sampled rd_i = 1 and mask_i[i] = 0. Otherwise it is 0.
- R4: After reset, oe_o is 2'b00, and it stays 0 until two edges have sampled an unmasked read.
- R5: Each byte of rd_data_o equals the matching byte of rd_data_i while its oe_o bit is 1. Otherwise that byte is 8'h00.
- R6: Each byte of wr_data_o equals the matching byte of wr_data_i while its wr_en_o bit is 1. Otherwise that byte is 8'h00.
- R7: In a read-to-write turnaround cycle, oe_o follows the mask and read flag from two edges earlier, and wr_en_o follows the current mask and wr_i. Neither side affects the other.
- R8: A mask value sampled on an edge with rd_i = 0 has no effect on oe_o two edges later, which stays 0 for that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_i | input | 1 | Read cycle indication |
| wr_i | input | 1 | Write cycle indication |
| mask_i | input | 2 | Byte mask, one bit per lane, high means masked |
| wr_data_i | input | 16 | Raw write data |
| rd_data_i | input | 16 | Raw read data from the array side |
| wr_en_o | output | 2 | Per-byte write enable, active high |
| wr_data_o | output | 16 | Write data with blocked bytes zeroed |
| oe_o | output | 2 | Per-byte output enable, active high |
| rd_data_o | output | 16 | Read data with disabled bytes zeroed |

## Verification
The write-side outputs (wr_en_o and wr_data_o) are combinational, so they are due in the cycle the stimulus is applied. The bench drives inputs just after a falling edge and checks these outputs one nanosecond later, before the next rising edge. The output enables are due after the second rising edge that follows the sampling edge. The bench therefore checks oe_o and rd_data_o at the second falling edge after the stimulus, before it applies new inputs. The turnaround and write-only cases check both sides in the same sampled window, so a design that mixes delayed and undelayed masks shows up as a wrong value.

// File: rtl/sdr_mask_pkg.sv
package sdr_mask_pkg;
    localparam int unsigned LANE_W_DEF  = 8;
    localparam int unsigned LANES_DEF   = 2;
    localparam int unsigned RD_LAT_DEF  = 2;

    // Mask polarity: a high bit disables the lane.
    typedef enum logic {
        LANE_OPEN   = 1'b0,
        LANE_MASKED = 1'b1
    } lane_mask_e;
endpackage

// File: rtl/mask_delay_line.sv
module mask_delay_line #(
    parameter int unsigned DEPTH   = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    typedef struct packed {
        logic [DEPTH-1:0] sh;
    } dl_state_t;

    dl_state_t st_d, st_q;

    generate
        if (DEPTH == 1) begin : g_single
            always_comb begin
                st_d    = st_q;
                st_d.sh = d_i;
            end
        end else begin : g_multi
            always_comb begin
                st_d    = st_q;
                st_d.sh = {st_q.sh[DEPTH-2:0], d_i};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{sh: {DEPTH{RST_VAL}}};
        else        st_q <= st_d;
    end

    assign q_o = st_q.sh[DEPTH-1];
endmodule

// File: rtl/byte_write_gate.sv
module byte_write_gate #(
    parameter int unsigned LANE_W = 8
) (
    input  logic              wr_i,
    input  logic              mask_i,
    input  logic [LANE_W-1:0] data_i,
    output logic              wr_en_o,
    output logic [LANE_W-1:0] data_o
);
    import sdr_mask_pkg::*;

    always_comb begin
        wr_en_o = wr_i && (lane_mask_e'(mask_i) == LANE_OPEN);
        data_o  = wr_en_o ? data_i : '0;
    end

    // R2: an enable never shows for a masked lane or outside a write
    always_comb begin
        a_r2_wr_needs_open: assert (!wr_en_o || (wr_i && !mask_i))
            else $error("write enable on masked lane");
    end
endmodule

// File: rtl/byte_read_gate.sv
module byte_read_gate #(
    parameter int unsigned LANE_W = 8
) (
    input  logic              oe_i,
    input  logic [LANE_W-1:0] data_i,
    output logic [LANE_W-1:0] data_o
);
    assign data_o = oe_i ? data_i : '0;
endmodule

// File: rtl/sdr_byte_mask_gate.sv
module sdr_byte_mask_gate #(
    parameter int unsigned LANES  = sdr_mask_pkg::LANES_DEF,
    parameter int unsigned LANE_W = sdr_mask_pkg::LANE_W_DEF,
    parameter int unsigned RD_LAT = sdr_mask_pkg::RD_LAT_DEF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rd_i,
    input  logic                    wr_i,
    input  logic [LANES-1:0]        mask_i,
    input  logic [LANES*LANE_W-1:0] wr_data_i,
    input  logic [LANES*LANE_W-1:0] rd_data_i,
    output logic [LANES-1:0]        wr_en_o,
    output logic [LANES*LANE_W-1:0] wr_data_o,
    output logic [LANES-1:0]        oe_o,
    output logic [LANES*LANE_W-1:0] rd_data_o
);
    localparam int unsigned DATA_W = LANES * LANE_W;
    localparam int unsigned CNT_W  = $clog2(RD_LAT + 1);

    logic             rd_dly;
    logic [LANES-1:0] mask_dly;

    // Read flag delay, resets to "no read" (R4)
    mask_delay_line #(.DEPTH(RD_LAT), .RST_VAL(1'b0)) u_rd_dly (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (rd_i),
        .q_o  (rd_dly)
    );

    generate
        for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
            // R1: lane ln owns bits [ln*LANE_W +: LANE_W]
            mask_delay_line #(.DEPTH(RD_LAT), .RST_VAL(1'b1)) u_mask_dly (
                .clk  (clk),
                .rst_n(rst_n),
                .d_i  (mask_i[ln]),
                .q_o  (mask_dly[ln])
            );

            assign oe_o[ln] = rd_dly & ~mask_dly[ln];

            byte_read_gate #(.LANE_W(LANE_W)) u_rgate (
                .oe_i  (oe_o[ln]),
                .data_i(rd_data_i[ln*LANE_W +: LANE_W]),
                .data_o(rd_data_o[ln*LANE_W +: LANE_W])
            );

            byte_write_gate #(.LANE_W(LANE_W)) u_wgate (
                .wr_i   (wr_i),
                .mask_i (mask_i[ln]),
                .data_i (wr_data_i[ln*LANE_W +: LANE_W]),
                .wr_en_o(wr_en_o[ln]),
                .data_o (wr_data_o[ln*LANE_W +: LANE_W])
            );

            // R5: a disabled lane drives zero
            a_r5_rd_zero_when_off: assert property (@(posedge clk) disable iff (!rst_n)
                !oe_o[ln] |-> (rd_data_o[ln*LANE_W +: LANE_W] == '0));
        end
    endgenerate

    // Edges since reset, saturating; used by the checks only
    typedef struct packed {
        logic [CNT_W-1:0] edges;
    } chk_state_t;

    chk_state_t chk_d, chk_q;

    always_comb begin
        chk_d = chk_q;
        if (chk_q.edges != CNT_W'(RD_LAT)) chk_d.edges = chk_q.edges + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chk_q <= '0;
        else        chk_q <= chk_d;
    end

    // R4: outputs stay disabled until the pipeline has filled
    a_r4_reset_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_q.edges != CNT_W'(RD_LAT)) |-> (oe_o == '0));

    generate
        if (RD_LAT == 2) begin : g_lat2_chk
            // R3 and R8: enable tracks read flag and mask from two edges back
            a_r3_oe_two_edges: assert property (@(posedge clk) disable iff (!rst_n)
                (chk_q.edges == CNT_W'(RD_LAT)) |->
                    (oe_o == ($past(rd_i, 2) ? ~$past(mask_i, 2) : {LANES{1'b0}})));
        end
    endgenerate

    logic unused_ok;
    assign unused_ok = ^{DATA_W[0]};
endmodule

// File: tb/tb_sdr_byte_mask_gate.sv
`timescale 1ns/100ps
module tb_sdr_byte_mask_gate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_i = 1'b0, wr_i = 1'b0;
    logic [1:0]  mask_i = 2'b11;
    logic [15:0] wr_data_i = '0, rd_data_i = '0;
    logic [1:0]  wr_en_o, oe_o;
    logic [15:0] wr_data_o, rd_data_o;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sdr_byte_mask_gate dut (
        .clk(clk), .rst_n(rst_n), .rd_i(rd_i), .wr_i(wr_i), .mask_i(mask_i),
        .wr_data_i(wr_data_i), .rd_data_i(rd_data_i),
        .wr_en_o(wr_en_o), .wr_data_o(wr_data_o),
        .oe_o(oe_o), .rd_data_o(rd_data_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply inputs just after a falling edge
    task automatic drive(input logic rd, input logic wr, input logic [1:0] m,
                         input logic [15:0] wd, input logic [15:0] rdd);
        @(negedge clk);
        rd_i = rd; wr_i = wr; mask_i = m; wr_data_i = wd; rd_data_i = rdd;
        #1;
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        chk("R4 oe in reset", {14'b0, oe_o}, 16'h0);
        rd_i = 1; mask_i = 2'b00; rd_data_i = 16'hA5C3;
        rst_n = 1;
        @(negedge clk);
        chk("R4 oe after one edge", {14'b0, oe_o}, 16'h0);
        chk("R5 rd data zero", rd_data_o, 16'h0);
        @(negedge clk);
        chk("R3 oe after two edges", {14'b0, oe_o}, 16'h3);
        chk("R5 rd data passes", rd_data_o, 16'hA5C3);
        drive(0, 0, 2'b11, 16'h0, 16'h0);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_write_masks();
        for (int m = 0; m < 4; m++) begin
            drive(0, 1, m[1:0], 16'hBEEF, 16'h0);
            chk("R2 wr_en same cycle", {14'b0, wr_en_o}, {14'b0, ~m[1:0]});
            chk("R6 R1 wr data lanes", wr_data_o,
                {m[1] ? 8'h00 : 8'hBE, m[0] ? 8'h00 : 8'hEF});
        end
        drive(0, 0, 2'b00, 16'h1234, 16'h0);
        chk("R2 no write without wr_i", {14'b0, wr_en_o}, 16'h0);
        chk("R6 data zero without write", wr_data_o, 16'h0);
    endtask

    task automatic t_read_patterns();
        // Pipeline of four reads with distinct masks, then idle
        logic [1:0] ms [4] = '{2'b01, 2'b10, 2'b00, 2'b11};
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (k >= 2) begin
                chk("R3 R1 oe pattern", {14'b0, oe_o}, {14'b0, ~ms[k-2]});
                chk("R5 R1 rd data lanes", rd_data_o,
                    {ms[k-2][1] ? 8'h00 : 8'h5A, ms[k-2][0] ? 8'h00 : 8'h3C});
            end
            rd_i = (k < 4); mask_i = (k < 4) ? ms[k] : 2'b00;
            wr_i = 0; rd_data_i = 16'h5A3C;
        end
        @(negedge clk);
        chk("R8 idle slot", {14'b0, oe_o}, 16'h0);
    endtask

    task automatic t_turnaround();
        drive(1, 0, 2'b10, 16'h0, 16'h7788);   // read, lane 0 open
        drive(1, 0, 2'b01, 16'h0, 16'h7788);   // read, lane 1 open
        drive(0, 1, 2'b01, 16'hCAFE, 16'h7788);// write, lane 1 open
        chk("R7 oe from delayed read", {14'b0, oe_o}, 16'h1);
        chk("R7 wr_en from current mask", {14'b0, wr_en_o}, 16'h2);
        chk("R7 wr data", wr_data_o, 16'hCA00);
        drive(0, 1, 2'b10, 16'hCAFE, 16'h7788);
        chk("R7 oe second read", {14'b0, oe_o}, 16'h2);
        chk("R7 wr_en second write", {14'b0, wr_en_o}, 16'h1);
        drive(0, 0, 2'b11, 16'h0, 16'h7788);
        chk("R8 write-only slot no oe", {14'b0, oe_o}, 16'h0);
        drive(0, 0, 2'b11, 16'h0, 16'h7788);
        chk("R8 write-only slot no oe 2", {14'b0, oe_o}, 16'h0);
    endtask

    initial begin
        t_reset();
        t_write_masks();
        t_read_patterns();
        t_turnaround();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule